// File: doc/BRIEF.md
# 16-bit Register-Pair Arithmetic Unit

This unit carries out the 16-bit register-pair instructions of a small 8-bit-style processor core. It handles three groups. The first adds one of the four pairs into HL. The second adds a signed 8-bit offset to the stack pointer. The third increments or decrements any pair. The core presents an opcode byte, the four current pair values, the incoming flags and an immediate byte, then pulses `start`. The unit returns the new pair value, the pair code to write, the updated flags, the instruction's cost in machine cycles, and a flag that marks an opcode it does not handle.

Results are captured on the clock edge that accepts `start`. They stay on the outputs until the next accepted start. A `done` pulse marks the end of the instruction's cost, counted as machine cycles of four clocks each. While an instruction is running, `busy` is high and `start` is ignored.

Top module: `pair_arith_unit`

## Requirements
- R1: Opcodes 0x09, 0x19, 0x29 and 0x39 add BC, DE, HL or SP (chosen by opcode bits 5:4 as 0, 1, 2, 3) to HL. The result is taken modulo 2^16, `dest` is 2 (HL) and `wr_en` is 1.
- R2: The flag vector is {Z, N, H, C} on bits 3 down to 0. On an HL add, Z passes through and N is 0. H is 1 when the low 12 bits of both operands sum above 0x0FFF. C is 1 when the full sum exceeds 0xFFFF.
- R3: Opcode 0xE8 writes SP plus the sign-extended immediate, modulo 2^16, with `dest` = 3 (SP) and `wr_en` = 1.
- R4: On 0xE8, Z and N are always 0. H is 1 when SP[3:0] plus imm[3:0] exceeds 0x0F. C is 1 when SP[7:0] plus the raw immediate byte exceeds 0xFF. Both rules apply whatever the offset's sign.
- R5: Opcodes 0x03, 0x13, 0x23 and 0x33 increment, and 0x0B, 0x1B, 0x2B and 0x3B decrement, the pair that bits 5:4 select. The result wraps modulo 2^16, `dest` equals bits 5:4 and `wr_en` is 1.
- R6: On increment and decrement, `flags_out` equals `flags_in` unchanged.
- R7: Any other opcode gives `illegal` = 1, `wr_en` = 0, `result` = 0, `dest` = 0, `flags_out` = `flags_in` and `mcycles` = 1.
- R8: `mcycles` is 2 for HL adds and pair increment/decrement, 4 for 0xE8 and 1 for an illegal opcode. `done` is high for exactly one clock, mcycles*4 clock edges after the accepting edge, and `busy` is high from the accepting edge until that edge.
- R9: A `start` that arrives while `busy` is high is ignored. All outputs hold and the running instruction's `done` timing is unchanged.
- R10: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Accept the presented instruction when not busy |
| opcode | input | 8 | Instruction opcode byte |
| imm | input | 8 | Immediate byte (offset for 0xE8) |
| bc_in | input | 16 | Current BC pair |
| de_in | input | 16 | Current DE pair |
| hl_in | input | 16 | Current HL pair |
| sp_in | input | 16 | Current stack pointer |
| flags_in | input | 4 | Incoming {Z,N,H,C} |
| result | output | 16 | New pair value |
| dest | output | 2 | Destination pair: 0 BC, 1 DE, 2 HL, 3 SP |
| wr_en | output | 1 | Result is to be written to `dest` |
| flags_out | output | 4 | Updated {Z,N,H,C} |
| illegal | output | 1 | Opcode not handled by this unit |
| mcycles | output | 3 | Instruction cost in machine cycles |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-clock end-of-instruction pulse |

## Verification
The assertions assume that `start` may come in any cycle, including while `busy` is high. They also assume that opcode, immediate, pair and flag inputs are valid only on the accepting edge. Past values of these inputs are therefore sampled only at an accepted start. The stimulus drives inputs between clock edges. It leaves `start` high for one edge per instruction, except in the deliberate overlap case. That case raises `start` during `busy` with a different opcode to show that it is ignored.

// File: rtl/pau_pkg.sv
package pau_pkg;
  localparam int unsigned PAIR_W = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned FLG_W  = 4;
  localparam int unsigned MC_W   = 3;

  // flag bit positions inside the flag vector
  localparam int unsigned FZ = 3;
  localparam int unsigned FN = 2;
  localparam int unsigned FH = 1;
  localparam int unsigned FC = 0;

  typedef enum logic [1:0] {
    OPK_ADD_HL = 2'd0,
    OPK_ADD_SP = 2'd1,
    OPK_STEP   = 2'd2,
    OPK_NONE   = 2'd3
  } op_kind_t;

  localparam logic [1:0] SEL_HL = 2'd2;
  localparam logic [1:0] SEL_SP = 2'd3;
endpackage

// File: rtl/pau_decode.sv
module pau_decode
  import pau_pkg::*;
(
  input  logic [BYTE_W-1:0] opcode,
  output op_kind_t          kind,
  output logic [1:0]        pair_sel,
  output logic              is_dec,
  output logic [MC_W-1:0]   mcyc
);
  always_comb begin
    kind     = OPK_NONE;
    pair_sel = opcode[5:4];
    is_dec   = opcode[3];
    mcyc     = MC_W'(1);
    if (opcode[7:6] == 2'b00) begin
      case (opcode[3:0])
        4'h9: begin
          kind = OPK_ADD_HL;
          mcyc = MC_W'(2);
        end
        4'h3, 4'hB: begin
          kind = OPK_STEP;
          mcyc = MC_W'(2);
        end
        default: ;
      endcase
    end
    if (opcode == 8'hE8) begin
      kind = OPK_ADD_SP;
      mcyc = MC_W'(4);
    end
  end
endmodule

// File: rtl/pau_datapath.sv
module pau_datapath
  import pau_pkg::*;
(
  input  op_kind_t          kind,
  input  logic [1:0]        pair_sel,
  input  logic              is_dec,
  input  logic [PAIR_W-1:0] bc,
  input  logic [PAIR_W-1:0] de,
  input  logic [PAIR_W-1:0] hl,
  input  logic [PAIR_W-1:0] sp,
  input  logic [BYTE_W-1:0] imm,
  input  logic [FLG_W-1:0]  flg_in,
  output logic [PAIR_W-1:0] res,
  output logic [1:0]        dst,
  output logic [FLG_W-1:0]  flg,
  output logic              wr,
  output logic              bad
);
  logic [PAIR_W-1:0] pairs [4];
  logic [PAIR_W-1:0] src;
  logic [PAIR_W-1:0] hl_sum;
  logic              hl_cy;
  logic              hl_hc;
  logic              sp_hc;
  logic              sp_cy;
  logic [PAIR_W-1:0] sext;

  assign pairs[0] = bc;
  assign pairs[1] = de;
  assign pairs[2] = hl;
  assign pairs[3] = sp;
  assign src      = pairs[pair_sel];

  assign {hl_cy, hl_sum} = {1'b0, hl} + {1'b0, src};
  assign hl_hc = ({1'b0, hl[11:0]} + {1'b0, src[11:0]}) > 13'h0FFF;
  assign sp_hc = ({1'b0, sp[3:0]} + {1'b0, imm[3:0]}) > 5'h0F;
  assign sp_cy = ({1'b0, sp[7:0]} + {1'b0, imm}) > 9'h0FF;
  assign sext  = {{(PAIR_W-BYTE_W){imm[BYTE_W-1]}}, imm};

  always_comb begin
    res = '0;
    dst = 2'd0;
    flg = flg_in;
    wr  = 1'b0;
    bad = 1'b0;
    case (kind)
      OPK_ADD_HL: begin
        res     = hl_sum;
        dst     = SEL_HL;
        wr      = 1'b1;
        flg[FN] = 1'b0;
        flg[FH] = hl_hc;
        flg[FC] = hl_cy;
      end
      OPK_ADD_SP: begin
        res = sp + sext;
        dst = SEL_SP;
        wr  = 1'b1;
        flg = {1'b0, 1'b0, sp_hc, sp_cy};
      end
      OPK_STEP: begin
        res = is_dec ? src - PAIR_W'(1) : src + PAIR_W'(1);
        dst = pair_sel;
        wr  = 1'b1;
      end
      default: bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/pau_sequencer.sv
module pau_sequencer #(
  parameter int unsigned MC_W       = 3,
  parameter int unsigned CLK_PER_MC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [MC_W-1:0] mcyc,
  output logic            busy,
  output logic            done
);
  localparam int unsigned MAX_CLKS = CLK_PER_MC * ((1 << MC_W) - 1);
  localparam int unsigned CNT_W    = $clog2(MAX_CLKS + 1);
  localparam logic [CNT_W-1:0] MC_CLKS = CNT_W'(CLK_PER_MC);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = (cnt_q == CNT_W'(1));
    if (load) begin
      cnt_d = CNT_W'(mcyc) * MC_CLKS;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign busy = (cnt_q != '0);
  assign done = done_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_BUSY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load && (mcyc != '0) |=> busy); // R8
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
endmodule

// File: rtl/pair_arith_unit.sv
module pair_arith_unit
  import pau_pkg::*;
#(
  parameter int unsigned CLK_PER_MC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [BYTE_W-1:0]  opcode,
  input  logic [BYTE_W-1:0]  imm,
  input  logic [PAIR_W-1:0]  bc_in,
  input  logic [PAIR_W-1:0]  de_in,
  input  logic [PAIR_W-1:0]  hl_in,
  input  logic [PAIR_W-1:0]  sp_in,
  input  logic [FLG_W-1:0]   flags_in,
  output logic [PAIR_W-1:0]  result,
  output logic [1:0]         dest,
  output logic               wr_en,
  output logic [FLG_W-1:0]   flags_out,
  output logic               illegal,
  output logic [MC_W-1:0]    mcycles,
  output logic               busy,
  output logic               done
);
  op_kind_t          kind;
  logic [1:0]        pair_sel;
  logic              is_dec;
  logic [MC_W-1:0]   mcyc;
  logic [PAIR_W-1:0] res_c;
  logic [1:0]        dst_c;
  logic [FLG_W-1:0]  flg_c;
  logic              wr_c, bad_c;
  logic              accept;

  pau_decode u_dec (
    .opcode   (opcode),
    .kind     (kind),
    .pair_sel (pair_sel),
    .is_dec   (is_dec),
    .mcyc     (mcyc)
  );

  pau_datapath u_dp (
    .kind     (kind),
    .pair_sel (pair_sel),
    .is_dec   (is_dec),
    .bc       (bc_in),
    .de       (de_in),
    .hl       (hl_in),
    .sp       (sp_in),
    .imm      (imm),
    .flg_in   (flags_in),
    .res      (res_c),
    .dst      (dst_c),
    .flg      (flg_c),
    .wr       (wr_c),
    .bad      (bad_c)
  );

  pau_sequencer #(.MC_W(MC_W), .CLK_PER_MC(CLK_PER_MC)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .mcyc  (mcyc),
    .busy  (busy),
    .done  (done)
  );

  assign accept = start && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result    <= '0;
      dest      <= '0;
      wr_en     <= 1'b0;
      flags_out <= '0;
      illegal   <= 1'b0;
      mcycles   <= '0;
    end else if (accept) begin
      result    <= res_c;
      dest      <= dst_c;
      wr_en     <= wr_c;
      flags_out <= flg_c;
      illegal   <= bad_c;
      mcycles   <= mcyc;
    end
  end

  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !wr_en); // R7
  AST_SPOFF_ZN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (opcode == 8'hE8) |=> (flags_out[FZ] == 1'b0) && (flags_out[FN] == 1'b0)); // R4
  AST_STEP_FLAGS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (opcode[7:6] == 2'b00) && (opcode[2:0] == 3'b011) |=> flags_out == $past(flags_in)); // R6
  AST_HLADD_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (opcode[7:6] == 2'b00) && (opcode[3:0] == 4'h9) |=> (dest == SEL_HL) && !flags_out[FN]); // R1
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    start && busy |=> $stable(result) && $stable(flags_out) && $stable(dest)); // R9
endmodule

// File: tb/pair_arith_unit_bench.sv
module pair_arith_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [7:0]  opcode, imm;
  logic [15:0] bc_in, de_in, hl_in, sp_in;
  logic [3:0]  flags_in;
  logic [15:0] result;
  logic [1:0]  dest;
  logic        wr_en;
  logic [3:0]  flags_out;
  logic        illegal;
  logic [2:0]  mcycles;
  logic        busy, done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pair_arith_unit u_pair_arith_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .imm(imm),
    .bc_in(bc_in), .de_in(de_in), .hl_in(hl_in), .sp_in(sp_in),
    .flags_in(flags_in), .result(result), .dest(dest), .wr_en(wr_en),
    .flags_out(flags_out), .illegal(illegal), .mcycles(mcycles),
    .busy(busy), .done(done)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected behaviour derived from the requirements
  task automatic model(input logic [7:0] op, input logic [7:0] im,
                       output logic [15:0] r, output logic [1:0] d, output logic [3:0] f,
                       output logic w, output logic il, output logic [2:0] mc);
    int p, s;
    case (op[5:4])
      2'd0: p = bc_in;
      2'd1: p = de_in;
      2'd2: p = hl_in;
      default: p = sp_in;
    endcase
    r = 16'h0; d = 2'd0; f = flags_in; w = 1'b1; il = 1'b0; mc = 3'd2;
    if (op == 8'hE8) begin
      s  = int'(sp_in) + (im[7] ? int'(im) - 256 : int'(im));
      r  = s[15:0]; d = 2'd3; mc = 3'd4;
      f  = {1'b0, 1'b0, ((sp_in & 16'hF) + (im & 8'hF)) > 15, ((sp_in & 16'hFF) + im) > 255};
    end else if ((op & 8'hCF) == 8'h09) begin
      s = int'(hl_in) + p;
      r = s[15:0]; d = 2'd2;
      f = {flags_in[3], 1'b0, ((hl_in & 16'hFFF) + (p & 'hFFF)) > 'hFFF, s > 'hFFFF};
    end else if ((op & 8'hCF) == 8'h03) begin
      s = (p + 1) % 65536; r = s[15:0]; d = op[5:4];
    end else if ((op & 8'hCF) == 8'h0B) begin
      s = (p + 65535) % 65536; r = s[15:0]; d = op[5:4];
    end else begin
      w = 1'b0; il = 1'b1; mc = 3'd1;
    end
  endtask

  task automatic set_regs(input logic [15:0] b, input logic [15:0] de, input logic [15:0] h,
                          input logic [15:0] s, input logic [3:0] f);
    bc_in = b; de_in = de; hl_in = h; sp_in = s; flags_in = f;
  endtask

  // issue one instruction, check done timing and all outputs
  task automatic run_op(input logic [7:0] op, input logic [7:0] im,
                        input string rres, input string rflg);
    logic [15:0] er; logic [1:0] ed; logic [3:0] ef; logic ew, eil; logic [2:0] emc;
    int n; bit timing_ok;
    model(op, im, er, ed, ef, ew, eil, emc);
    @(negedge clk);
    opcode = op; imm = im; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    n = emc * 4;
    timing_ok = 1;
    for (int k = 1; k <= n; k++) begin
      @(posedge clk); #1;
      if (k < n && (done !== 1'b0 || busy !== 1'b1)) timing_ok = 0;
      if (k == n && (done !== 1'b1 || busy !== 1'b0)) timing_ok = 0;
    end
    chk("R8", $sformatf("done timing op=%0h", op), {31'd0, timing_ok}, 32'd1);
    chk("R8", "mcycles", mcycles, emc);
    chk(rres, $sformatf("result op=%0h", op), result, er);
    chk(rres, "dest", dest, ed);
    chk(rres, "wr_en", wr_en, ew);
    chk(rflg, $sformatf("flags op=%0h", op), flags_out, ef);
    chk(eil ? "R7" : rres, "illegal", illegal, eil);
    @(posedge clk); #1;
    chk("R8", "done one clock", done, 1'b0);
  endtask

  task automatic t_reset;
    chk("R10", "result after reset", result, 0);
    chk("R10", "flags after reset", flags_out, 0);
    chk("R10", "ctl after reset", {wr_en, illegal, busy, done, mcycles, dest}, 0);
  endtask

  task automatic t_add_hl;
    set_regs(16'h0F00, 16'h1234, 16'hF100, 16'h0001, 4'b1000);
    run_op(8'h09, 8'h00, "R1", "R2");   // R1 R2: H and C set, Z kept
    set_regs(16'h0000, 16'h0000, 16'h0800, 16'h0000, 4'b0111);
    run_op(8'h29, 8'h00, "R1", "R2");   // HL+HL = 0x1000, H set, C clear
    set_regs(16'h0000, 16'h0001, 16'h1000, 16'h0234, 4'b0101);
    run_op(8'h39, 8'h00, "R1", "R2");   // no carries, N cleared
    run_op(8'h19, 8'h00, "R1", "R2");
  endtask

  task automatic t_add_sp;
    set_regs(16'h0, 16'h0, 16'h0, 16'h12F8, 4'b1100);
    run_op(8'hE8, 8'h0A, "R3", "R4");   // positive offset, H and C set, Z N cleared
    set_regs(16'h0, 16'h0, 16'h0, 16'h0001, 4'b1111);
    run_op(8'hE8, 8'hFF, "R3", "R4");   // -1: result 0, H and C set
    set_regs(16'h0, 16'h0, 16'h0, 16'h0100, 4'b0000);
    run_op(8'hE8, 8'h80, "R3", "R4");   // -128: result 0x0080, no carries
  endtask

  task automatic t_step;
    set_regs(16'h0000, 16'h5555, 16'hAAAA, 16'hFFFF, 4'b1010);
    run_op(8'h33, 8'h00, "R5", "R6");   // SP wraps to 0
    run_op(8'h0B, 8'h00, "R5", "R6");   // BC wraps to FFFF
    run_op(8'h13, 8'h00, "R5", "R6");
    run_op(8'h2B, 8'h00, "R5", "R6");
  endtask

  task automatic t_illegal;
    set_regs(16'h1111, 16'h2222, 16'h3333, 16'h4444, 4'b0110);
    run_op(8'h00, 8'h00, "R7", "R7");
    run_op(8'hF9, 8'h00, "R7", "R7");
  endtask

  task automatic t_busy_ignore;
    bit timing_ok;
    set_regs(16'h0001, 16'h0, 16'h0, 16'h0, 4'b0000);
    @(negedge clk);
    opcode = 8'h03; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    timing_ok = 1;
    for (int k = 1; k <= 8; k++) begin
      if (k == 3) begin
        opcode = 8'hE8; imm = 8'h7F; start = 1'b1;   // R9: start during busy
      end
      @(posedge clk); #1;
      start = 1'b0;
      if (k < 8 && done !== 1'b0) timing_ok = 0;
      if (k == 8 && done !== 1'b1) timing_ok = 0;
    end
    chk("R9", "done timing with overlapping start", {31'd0, timing_ok}, 32'd1);
    chk("R9", "result held", result, 16'h0002);
    chk("R9", "dest held", dest, 2'd0);
    chk("R9", "mcycles held", mcycles, 3'd2);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; opcode = 8'h00; imm = 8'h00;
    set_regs(16'h0, 16'h0, 16'h0, 16'h0, 4'h0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_add_hl();
    t_add_sp();
    t_step();
    t_illegal();
    t_busy_ignore();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule